// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits between a processor whose low address byte and data byte share the same eight pins and the devices on its external bus: a RAM that fills the upper half of a 16-bit address space and a bank of memory-mapped I/O ports. While the address strobe is high, the block records the low address byte from the shared pins. Once the strobe drops, the same pins carry data. The high address lines go through to the RAM unchanged, and the recorded byte completes the RAM address.

The decode is combinational from the high address lines, the read/write line, the bus enable clock and a supply-valid input. The RAM chip enable needs A15 high, the enable clock high and a valid supply. The one-of-eight I/O select needs A15 low, A14 high and the enable clock high. This makes the two regions mutually exclusive. A13, A12 and the read/write line pick the I/O output. Two of the outputs are served inside the block. A read from the 0x7000 window drives a sensor byte onto the data pins. A write to that window loads a motor output register, which is updated when the write strobe ends.

All registers in the block run on a single system clock, `clk`, and reset synchronously.

Top module: `mux_bus_decoder`

## Requirements
- R1: With `addr_strobe` high at a clock edge, the byte on `ad_bus_in` appears on `ram_addr[7:0]` after that edge. While the strobe stays low, `ram_addr[7:0]` holds its value.
- R2: `ram_addr[14:8]` equals `addr_hi[6:0]` in the same cycle.
- R3: `ram_ce` is high exactly when A15 (`addr_hi[7]`) is 1, `e_clk` is 1 and `supply_ok` is 1.
- R4: Whenever `supply_ok` is 0, `ram_ce` is 0, whatever the address and the enable clock are. A write attempted in that state leaves the RAM contents unchanged.
- R5: `io_sel` is all zero unless A15 is 0, A14 is 1 and `e_clk` is 1.
- R6: When the I/O window is enabled, exactly one bit of `io_sel` is set. Its index is {A13, A12, rw}, where rw is 1 for a read and 0 for a write. `io_sel` is never nonzero while `ram_ce` is high.
- R7: `ad_bus_oe` is high only while `io_sel[7]` is high, which means a read anywhere in 0x7000 to 0x7FFF with the enable clock high. While it is high, `ad_bus_out` equals `sensor_in`.
- R8: `motor_q` takes the `ad_bus_in` byte from the last clock edge at which `io_sel[6]` was high. It becomes visible one clock after the first edge at which `io_sel[6]` is seen low again.
- R9: `motor_q` keeps its value across every other bus cycle, including writes to the other I/O ports (codes 0 to 5) and RAM writes.
- R10: After a synchronous reset, `motor_q` and `ram_addr[7:0]` are 0x00 and `ad_bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 8 | High address lines A15..A8 |
| ad_bus_in | input | 8 | Shared address/data pins as seen by the block |
| addr_strobe | input | 1 | High while the shared pins carry the low address byte |
| rw | input | 1 | 1 = read, 0 = write |
| e_clk | input | 1 | Bus enable clock; qualifies every access |
| supply_ok | input | 1 | Supply within range; gates the RAM enable |
| sensor_in | input | 8 | Digital sensor byte returned on reads of 0x7xxx |
| ram_ce | output | 1 | RAM chip enable, active high |
| ram_addr | output | 15 | RAM address: A14..A8 and the latched low byte |
| io_sel | output | 8 | One-of-eight I/O selects, active high |
| ad_bus_out | output | 8 | Byte the block drives onto the shared pins |
| ad_bus_oe | output | 1 | Drive enable for `ad_bus_out` |
| motor_q | output | 8 | Motor output register |

## Verification
The assertions assume that the processor never raises the address strobe while the enable clock is high. They also assume that reset is held for at least three clocks, so the two-cycle look-back on the motor register stays inside the reset window. The bench drives every bus cycle as a strobe phase followed by an enable phase, with the strobe already low. Its randomized cycles keep that ordering and keep the processor off the shared pins whenever the block is driving them. Addresses, supply state and sensor bytes are randomized freely, so the decode is exercised across all regions while the bus-phase ordering is never violated.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int N_SEL  = 1 << SEL_W;
    localparam int RADR_W = ADDR_W - 1;

    localparam int SENSOR_CODE = 7;
    localparam int MOTOR_CODE  = 6;

    typedef struct packed {
        logic             upper;
        logic             io_window;
        logic [SEL_W-1:0] code;
    } region_t;

    function automatic region_t classify(input logic [HI_W-1:0] hi, input logic rd);
        region_t r;
        r.upper     = hi[HI_W-1];
        r.io_window = !hi[HI_W-1] && hi[HI_W-2];
        r.code      = {hi[HI_W-3], hi[HI_W-4], rd};
        return r;
    endfunction
endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch
    import mbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] low_q
);
    always_ff @(posedge clk) begin
        if (rst)
            low_q <= '0;
        else if (strobe)
            low_q <= pins;
    end
endmodule

// File: rtl/mbd_decode.sv
module mbd_decode
    import mbd_pkg::*;
(
    input  logic [HI_W-1:0]  addr_hi,
    input  logic             rw,
    input  logic             e_clk,
    input  logic             supply_ok,
    output logic             ram_ce,
    output logic [N_SEL-1:0] io_sel
);
    region_t reg_info;
    logic    io_en;

    assign reg_info = classify(addr_hi, rw);
    assign ram_ce   = reg_info.upper && e_clk && supply_ok;
    assign io_en    = reg_info.io_window && e_clk;

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        assign io_sel[i] = io_en && (reg_info.code == SEL_W'(i));
    end
endmodule

// File: rtl/mbd_io_port.sv
module mbd_io_port
    import mbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] pins,
    input  logic [DATA_W-1:0] sensor_in,
    output logic [DATA_W-1:0] drive_val,
    output logic              drive_en,
    output logic [DATA_W-1:0] motor_q
);
    logic              wr_sel_q;
    logic [DATA_W-1:0] hold_q;

    assign drive_en  = rd_sel;
    assign drive_val = rd_sel ? sensor_in : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel_q <= 1'b0;
            hold_q   <= '0;
            motor_q  <= '0;
        end else begin
            wr_sel_q <= wr_sel;
            if (wr_sel)
                hold_q <= pins;
            if (wr_sel_q && !wr_sel)
                motor_q <= hold_q;
        end
    end
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
    import mbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [DATA_W-1:0] ad_bus_in,
    input  logic              addr_strobe,
    input  logic              rw,
    input  logic              e_clk,
    input  logic              supply_ok,
    input  logic [DATA_W-1:0] sensor_in,
    output logic              ram_ce,
    output logic [RADR_W-1:0] ram_addr,
    output logic [N_SEL-1:0]  io_sel,
    output logic [DATA_W-1:0] ad_bus_out,
    output logic              ad_bus_oe,
    output logic [DATA_W-1:0] motor_q
);
    logic [DATA_W-1:0] low_byte;

    mbd_addr_latch i_latch (
        .clk    (clk),
        .rst    (rst),
        .strobe (addr_strobe),
        .pins   (ad_bus_in),
        .low_q  (low_byte)
    );

    mbd_decode i_decode (
        .addr_hi   (addr_hi),
        .rw        (rw),
        .e_clk     (e_clk),
        .supply_ok (supply_ok),
        .ram_ce    (ram_ce),
        .io_sel    (io_sel)
    );

    mbd_io_port i_port (
        .clk       (clk),
        .rst       (rst),
        .rd_sel    (io_sel[SENSOR_CODE]),
        .wr_sel    (io_sel[MOTOR_CODE]),
        .pins      (ad_bus_in),
        .sensor_in (sensor_in),
        .drive_val (ad_bus_out),
        .drive_en  (ad_bus_oe),
        .motor_q   (motor_q)
    );

    assign ram_addr = {addr_hi[HI_W-2:0], low_byte};
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
    import mbd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              e_clk,
    input logic              ram_ce,
    input logic [N_SEL-1:0]  io_sel,
    input logic              ad_bus_oe,
    input logic [DATA_W-1:0] ad_bus_out,
    input logic [DATA_W-1:0] sensor_in,
    input logic [DATA_W-1:0] motor_q
);
    a_r4_no_ram_without_supply: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !ram_ce);

    a_r6_ram_io_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ram_ce && (io_sel != '0)));

    a_r6_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(io_sel));

    a_r5_idle_without_e: assert property (@(posedge clk) disable iff (rst)
        !e_clk |-> (io_sel == '0) && !ram_ce);

    a_r7_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
        ad_bus_oe |-> io_sel[SENSOR_CODE] && (ad_bus_out == sensor_in));

    a_r9_motor_holds: assert property (@(posedge clk) disable iff (rst)
        $stable(motor_q) || ($past(io_sel[MOTOR_CODE], 2) && !$past(io_sel[MOTOR_CODE])));
endmodule

bind mux_bus_decoder mbd_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .e_clk      (e_clk),
    .ram_ce     (ram_ce),
    .io_sel     (io_sel),
    .ad_bus_oe  (ad_bus_oe),
    .ad_bus_out (ad_bus_out),
    .sensor_in  (sensor_in),
    .motor_q    (motor_q)
);

// File: tb/test_mux_bus_decoder.sv
module test_mux_bus_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr_hi = '0;
    logic [7:0]  cpu_drv = '0;
    logic [7:0]  ad_bus_in;
    logic        addr_strobe = 1'b0;
    logic        rw = 1'b1;
    logic        e_clk = 1'b0;
    logic        supply_ok = 1'b1;
    logic [7:0]  sensor_in = '0;
    logic        ram_ce;
    logic [14:0] ram_addr;
    logic [7:0]  io_sel;
    logic [7:0]  ad_bus_out;
    logic        ad_bus_oe;
    logic [7:0]  motor_q;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign ad_bus_in = ad_bus_oe ? ad_bus_out : cpu_drv;

    mux_bus_decoder i_mux_bus_decoder (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_bus_in(ad_bus_in),
        .addr_strobe(addr_strobe), .rw(rw), .e_clk(e_clk), .supply_ok(supply_ok),
        .sensor_in(sensor_in), .ram_ce(ram_ce), .ram_addr(ram_addr), .io_sel(io_sel),
        .ad_bus_out(ad_bus_out), .ad_bus_oe(ad_bus_oe), .motor_q(motor_q)
    );

    // RAM stub: stores on enabled write clocks
    logic [7:0] ram_mem [256];
    initial for (int i = 0; i < 256; i++) ram_mem[i] = 8'h00;
    always @(posedge clk) if (ram_ce && !rw) ram_mem[ram_addr[7:0]] <= ad_bus_in;

    // Behavioural reference state
    int m_low = 0, m_motor = 0, m_hold = 0;
    bit m_prev_wr = 0;

    function automatic bit m_wr_sel();
        return e_clk && addr_hi[7:4] == 4'h7 && !rw;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_low = 0; m_motor = 0; m_hold = 0; m_prev_wr = 0;
        end else begin
            bit cur;
            cur = m_wr_sel();
            if (addr_strobe) m_low = ad_bus_in;
            if (m_prev_wr && !cur) m_motor = m_hold;
            if (cur) m_hold = ad_bus_in;
            m_prev_wr = cur;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_sel;
        bit exp_ram, io_en;
        exp_ram = addr_hi[7] && e_clk && supply_ok;
        io_en   = !addr_hi[7] && addr_hi[6] && e_clk;
        exp_sel = io_en ? (1 << {addr_hi[5], addr_hi[4], rw}) : 0;
        chk(ram_addr[7:0] == m_low[7:0], "R1 low byte", ram_addr[7:0], m_low);
        chk(ram_addr[14:8] == addr_hi[6:0], "R2 high bits", ram_addr[14:8], addr_hi[6:0]);
        chk(ram_ce == exp_ram, "R3 ram enable", ram_ce, exp_ram);
        chk(io_sel == exp_sel[7:0], "R5/R6 io select", io_sel, exp_sel);
        chk(ad_bus_oe == exp_sel[7], "R7 drive enable", ad_bus_oe, exp_sel[7]);
        if (exp_sel[7])
            chk(ad_bus_out == sensor_in, "R7 sensor byte", ad_bus_out, sensor_in);
        chk(motor_q == m_motor[7:0], "R8/R9 motor register", motor_q, m_motor);
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic bus_cycle(input logic [15:0] a, input bit rd, input logic [7:0] d);
        tick();
        addr_hi = a[15:8]; cpu_drv = a[7:0]; rw = rd; addr_strobe = 1'b1; e_clk = 1'b0;
        tick();
        addr_strobe = 1'b0; cpu_drv = rd ? 8'h00 : d; e_clk = 1'b1;
        tick();
        tick();
        e_clk = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(motor_q == 8'h00, "R10 motor reset", motor_q, 0);
        chk(ram_addr[7:0] == 8'h00, "R10 low byte reset", ram_addr[7:0], 0);
        chk(!ad_bus_oe, "R10 no drive", ad_bus_oe, 0);

        // R8 motor write, visible after the select ends
        bus_cycle(16'h7000, 1'b0, 8'hF0);
        tick();
        chk(motor_q == 8'hF0, "R8 motor write", motor_q, 8'hF0);

        // R9 writes to other ports and RAM leave the motor register alone
        bus_cycle(16'h6000, 1'b0, 8'h11);
        bus_cycle(16'h4A00, 1'b0, 8'h22);
        bus_cycle(16'h9055, 1'b0, 8'h33);
        chk(motor_q == 8'hF0, "R9 motor holds", motor_q, 8'hF0);
        chk(ram_mem[8'h55] == 8'h33, "R1 ram stub write", ram_mem[8'h55], 8'h33);

        // R7 read anywhere in the sensor window
        sensor_in = 8'h5A;
        tick();
        addr_hi = 8'h7F; cpu_drv = 8'h3C; rw = 1'b1; addr_strobe = 1'b1;
        tick();
        addr_strobe = 1'b0; e_clk = 1'b1;
        tick();
        chk(ad_bus_oe && ad_bus_out == 8'h5A, "R7 sensor read", ad_bus_out, 8'h5A);
        chk(ram_addr[7:0] == 8'h3C, "R1 latched low", ram_addr[7:0], 8'h3C);
        e_clk = 1'b0;
        tick();

        // R4 supply invalid blocks RAM writes
        supply_ok = 1'b0;
        bus_cycle(16'h9055, 1'b0, 8'hEE);
        chk(ram_mem[8'h55] == 8'h33, "R4 ram protected", ram_mem[8'h55], 8'h33);
        chk(!ram_ce, "R4 enable low", ram_ce, 0);
        supply_ok = 1'b1;

        // Randomized bus cycles across all regions
        for (int n = 0; n < 400; n++) begin
            sensor_in = 8'($urandom);
            supply_ok = ($urandom % 4) != 0;
            bus_cycle(16'($urandom), 1'($urandom), 8'($urandom));
        end

        // R8 back-to-back motor writes
        bus_cycle(16'h7123, 1'b0, 8'h81);
        bus_cycle(16'h7FFF, 1'b0, 8'h7E);
        tick();
        chk(motor_q == 8'h7E, "R8 second write wins", motor_q, 8'h7E);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule